// File: doc/BRIEF.md
# GPIO Interrupt Detection and Status Unit

This block watches a parameterised set of already-synchronised GPIO input levels and turns them into interrupt events. Every pin has two configuration bits, a mode bit and a polarity bit. Together they pick one of four triggers: rising edge, falling edge, low level or high level. A detected event latches into a per-pin status bit. The status bits are gathered into 32-bit words, one word per group of 32 pins. Software clears a status bit by writing 1 to it, so it can acknowledge a pin before servicing it and still not lose an edge that arrives later.

A second set of 32-bit words holds the per-pin enable mask. A pin is pending when its status bit and its enable bit are both set. A single registered interrupt line is the OR of all pending pins. Status bits latch whatever the enable says, so enabling a pin that already has a recorded event raises the interrupt on the following cycle.

Register access uses a plain single-cycle port: a write strobe with address and data, and a combinational read-data output. It is a control port, not a data stream, so it has no valid/ready handshake and no back-pressure. The parameter `NUM_PINS` may range from 1 to 128. The status window then spans at most four words and cannot overlap the enable window.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every status bit, every enable bit and `irq_out` read 0.
- R2: With mode 0 and polarity 0, a pin's status bit is set in the clock edge that first samples a 0-to-1 change of its level. A 1-to-0 change or a steady level sets nothing.
- R3: With mode 0 and polarity 1, a pin's status bit is set on a 1-to-0 change of its level. A 0-to-1 change sets nothing.
- R4: With mode 1 and polarity 0, the status bit is set on every clock edge while the level is 0. After a clearing write it is still set while the level stays 0.
- R5: With mode 1 and polarity 1, the status bit is set on every clock edge while the level is 1. It stays clear once the level is 0 and the bit has been cleared.
- R6: A write to a status word clears exactly the bits written as 1. Bits written as 0 are unchanged, and writing 0xFFFFFFFF clears the whole group.
- R7: If a pin's event and a clearing write for that pin fall on the same clock edge, the status bit ends up set.
- R8: Enable words are read/write. Bits for pins that do not exist read 0 and ignore writes.
- R9: `irq_out` is registered. One cycle after the OR over all pins of (status AND enable) changes, `irq_out` follows it. Writing 0 to an enable word masks that group.
- R10: Status bits latch while their enable is 0. Enabling an already set pin raises `irq_out` one cycle after the enable write takes effect.
- R11: Status word g sits at address 0x80 + 4·g and enable word g at 0x90 + 4·g. Pin p maps to bit p mod 32 of word p div 32. Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NUM_PINS | Synchronised pin input levels |
| trig_mode | input | NUM_PINS | Per-pin mode bit: 0 edge, 1 level |
| trig_pol | input | NUM_PINS | Per-pin polarity bit (see R2 to R5) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Registered aggregated interrupt |

## Verification
The assertions assume the pin levels and configuration bits are already synchronous to `clk` and settle between edges. They also assume the register port is driven only with stable values around the sampling edge. The bench meets both assumptions by changing every input on the falling edge and reading combinational data half a cycle later. Configuration bits are changed only while the affected pin sits at a level that the new trigger does not treat as an event. After such a change, each test clears the group before it checks anything.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WORD_W = 32;

  // trigger encoding is {mode, polarity}
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_e;

  function automatic logic trig_hit(input trig_e mode, input logic cur, input logic last);
    logic hit;
    case (mode)
      TRIG_RISE: hit = cur & ~last;
      TRIG_FALL: hit = ~cur & last;
      TRIG_LOW:  hit = ~cur;
      default:   hit = cur;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic [NUM_PINS-1:0] trig_mode,
  input  logic [NUM_PINS-1:0] trig_pol,
  output logic [NUM_PINS-1:0] pin_event
);

  logic [NUM_PINS-1:0] level_q;
  logic                hist_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      hist_ok <= 1'b0;
    end else begin
      level_q <= pin_level;
      hist_ok <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    trig_e mode_i;
    assign mode_i       = trig_e'({trig_mode[i], trig_pol[i]});
    assign pin_event[i] = trig_hit(mode_i, pin_level[i], level_q[i]);

    // edge modes: an unchanged level since the last edge yields no event
    assert_edge_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && !trig_mode[i] && pin_level[i] == $past(pin_level[i])) |-> !pin_event[i]);
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int                NUM_PINS  = 40,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] EN_BASE   = 8'h90
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_event,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic [NUM_PINS-1:0] pending
);

  localparam int                NUM_GRP = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int                GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int                PAD_W   = NUM_GRP * WORD_W;
  localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(NUM_GRP * 4);

  logic [ADDR_W-1:0]   stat_off, en_off;
  logic                stat_hit, en_hit;
  logic [GRP_W-1:0]    stat_grp, en_grp;
  logic [NUM_PINS-1:0] stat_q, en_q, clr_vec, en_nxt;
  logic [PAD_W-1:0]    stat_pad, en_pad;

  assign stat_off = reg_addr - STAT_BASE;
  assign en_off   = reg_addr - EN_BASE;
  assign stat_hit = (reg_addr >= STAT_BASE) && (stat_off < SPAN) && (stat_off[1:0] == 2'b00);
  assign en_hit   = (reg_addr >= EN_BASE) && (en_off < SPAN) && (en_off[1:0] == 2'b00);
  assign stat_grp = stat_off[2 +: GRP_W];
  assign en_grp   = en_off[2 +: GRP_W];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    localparam int G = i / WORD_W;
    localparam int B = i % WORD_W;
    assign clr_vec[i] = reg_wr && stat_hit && (stat_grp == GRP_W'(G)) && reg_wdata[B];
    assign en_nxt[i]  = (reg_wr && en_hit && (en_grp == GRP_W'(G))) ? reg_wdata[B] : en_q[i];

    // a clearing write without a coincident event empties the bit
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !pin_event[i]) |=> !stat_q[i]);
    // an event always leaves the bit set, even against a clear
    assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pin_event[i] |=> stat_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | pin_event;
      en_q   <= en_nxt;
    end
  end

  if (PAD_W > NUM_PINS) begin : g_pad
    assign stat_pad = {{(PAD_W-NUM_PINS){1'b0}}, stat_q};
    assign en_pad   = {{(PAD_W-NUM_PINS){1'b0}}, en_q};
  end else begin : g_nopad
    assign stat_pad = stat_q;
    assign en_pad   = en_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (stat_hit)    reg_rdata = stat_pad[int'(stat_grp) * WORD_W +: WORD_W];
    else if (en_hit) reg_rdata = en_pad[int'(en_grp) * WORD_W +: WORD_W];
  end

  assign pending = stat_q & en_q;

  // writes outside the enable window leave the mask alone
  assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && en_hit)) |=> $stable(en_q));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic [NUM_PINS-1:0] trig_mode,
  input  logic [NUM_PINS-1:0] trig_pol,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                irq_out
);

  logic [NUM_PINS-1:0] pin_event;
  logic [NUM_PINS-1:0] pending;
  logic                irq_q;

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_level (pin_level),
    .trig_mode (trig_mode),
    .trig_pol  (trig_pol),
    .pin_event (pin_event)
  );

  gpio_irq_regs #(
    .NUM_PINS  (NUM_PINS),
    .ADDR_W    (ADDR_W),
    .STAT_BASE (ADDR_W'(8'h80)),
    .EN_BASE   (ADDR_W'(8'h90))
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_event (pin_event),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pending   (pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pending;
  end

  assign irq_out = irq_q;

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pending) |=> irq_out);
  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pending) |=> !irq_out);

endmodule

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] pin_level = '0;
  logic [NP-1:0] trig_mode = '0;
  logic [NP-1:0] trig_pol  = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_unit #(.NUM_PINS(NP), .ADDR_W(8)) u_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .trig_mode(trig_mode),
    .trig_pol(trig_pol), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic clear_all();
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h84, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h80, d); chk("R1 status0", d, 0);
    rd(8'h84, d); chk("R1 status1", d, 0);
    rd(8'h90, d); chk("R1 enable0", d, 0);
    chk("R1 irq", {31'b0, irq_out}, 0);
  endtask

  task automatic t_rising();
    logic [31:0] d;
    pin_level[3] = 1'b1; step();
    rd(8'h80, d); chk("R2 rise sets", d & 32'h8, 32'h8);
    wr(8'h80, 32'h8);
    step(); rd(8'h80, d); chk("R2 steady high no event", d & 32'h8, 0);
    pin_level[3] = 1'b0; step();
    rd(8'h80, d); chk("R2 fall ignored", d & 32'h8, 0);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    trig_pol[5] = 1'b1; step();
    pin_level[5] = 1'b1; step();
    rd(8'h80, d); chk("R3 rise ignored", d & 32'h20, 0);
    pin_level[5] = 1'b0; step();
    rd(8'h80, d); chk("R3 fall sets", d & 32'h20, 32'h20);
    wr(8'h80, 32'h20);
    trig_pol[5] = 1'b0;
  endtask

  task automatic t_level_low();
    logic [31:0] d;
    pin_level[33] = 1'b1; step();
    trig_mode[33] = 1'b1; step();
    clear_all(); step();
    rd(8'h84, d); chk("R4 inactive level", d, 0);
    pin_level[33] = 1'b0; step();
    rd(8'h84, d); chk("R11 pin33 -> word1 bit1 (R4)", d, 32'h2);
    wr(8'h84, 32'h2);
    rd(8'h84, d); chk("R4 re-sets while low", d, 32'h2);
    pin_level[33] = 1'b1; step();
    wr(8'h84, 32'h2);
    rd(8'h84, d); chk("R4 stays clear when high", d, 0);
    trig_mode[33] = 1'b0; step();
    pin_level[33] = 1'b0; step();
    clear_all();
  endtask

  task automatic t_level_high();
    logic [31:0] d;
    trig_mode[39] = 1'b1; trig_pol[39] = 1'b1; step();
    clear_all(); step();
    rd(8'h84, d); chk("R5 inactive level", d & 32'h80, 0);
    pin_level[39] = 1'b1; step(); step();
    rd(8'h84, d); chk("R5 high sets", d & 32'h80, 32'h80);
    pin_level[39] = 1'b0; step();
    wr(8'h84, 32'h80); step();
    rd(8'h84, d); chk("R5 low stays clear", d & 32'h80, 0);
    trig_mode[39] = 1'b0; trig_pol[39] = 1'b0; step();
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    clear_all();
    pin_level[2:0] = 3'b111; step();
    wr(8'h80, 32'h2);
    rd(8'h80, d); chk("R6 clear only bit1", d & 32'h7, 32'h5);
    wr(8'h80, 32'h0);
    rd(8'h80, d); chk("R6 zero write no change", d & 32'h7, 32'h5);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, d); chk("R6 all-ones clears group", d, 0);
    pin_level[2:0] = 3'b000; step();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pin_level[11] = 1'b1; step();
    pin_level[10] = 1'b1;
    wr(8'h80, 32'hC00);
    rd(8'h80, d); chk("R7 event beats clear", d & 32'hC00, 32'h400);
    wr(8'h80, 32'hFFFF_FFFF);
    pin_level[11:10] = 2'b00; step();
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h90, 32'hA5A5_5A5A);
    rd(8'h90, d); chk("R8 enable0 readback", d, 32'hA5A5_5A5A);
    wr(8'h94, 32'hFFFF_FFFF);
    rd(8'h94, d); chk("R8 enable1 absent bits 0", d, 32'h0000_00FF);
    wr(8'h90, 0); wr(8'h94, 0);
    rd(8'h90, d); chk("R8 enable0 cleared", d, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    clear_all();
    pin_level[20] = 1'b1; step(); step();
    rd(8'h80, d); chk("R10 latch while disabled", d & 32'h10_0000, 32'h10_0000);
    chk("R10 irq low while disabled", {31'b0, irq_out}, 0);
    wr(8'h90, 32'h10_0000);
    chk("R9 irq registered latency", {31'b0, irq_out}, 0);
    step(); chk("R10 irq on enable", {31'b0, irq_out}, 1);
    wr(8'h90, 32'h0);
    chk("R9 mask latency", {31'b0, irq_out}, 1);
    step(); chk("R9 mask drops irq", {31'b0, irq_out}, 0);
    wr(8'h90, 32'h10_0000); step();
    chk("R9 irq back", {31'b0, irq_out}, 1);
    wr(8'h80, 32'h10_0000); step();
    chk("R9 clear drops irq", {31'b0, irq_out}, 0);
    wr(8'h90, 0);
    pin_level[20] = 1'b0; step();
  endtask

  task automatic t_addr();
    logic [31:0] d;
    wr(8'h90, 32'h0000_0F0F);
    wr(8'h98, 32'hFFFF_FFFF);
    wr(8'h91, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h90, d); chk("R11 stray writes ignored", d, 32'h0000_0F0F);
    rd(8'h00, d); chk("R11 unmapped read 0", d, 0);
    rd(8'h88, d); chk("R11 absent group read 0", d, 0);
    pin_level[7] = 1'b1; step();
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h80, d); chk("R11 stray clear ignored", d & 32'h80, 32'h80);
    wr(8'h90, 0); clear_all();
    pin_level[7] = 1'b0; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_rising();
    t_falling();
    t_level_low();
    t_level_high();
    t_w1c();
    t_collide();
    t_enable();
    t_irq();
    t_addr();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule